// File: doc/BRIEF.md
# Framebuffer Transfer Address Walker

This block drives a framebuffer copy that can change the pixel layout on the way. After a start pulse it captures a transfer configuration. The configuration holds the source and destination dimensions, the bytes per pixel on each side, two layout flags, a vertical flip flag and a downscale mode. The block then walks the destination image row by row. For each destination pixel it issues one or more source reads and then one destination write. Either side can be stored linearly or in 8x8 tiles, where the pixels inside a tile follow a Z-order curve.

Source pixels arrive as 32-bit words with four 8-bit channels. The read port is combinational: `rdData` must reflect `rdAddr` in the same cycle. When downscaling is on, the block reads 2 or 4 pixels that sit next to each other in storage and averages them channel by channel. Any configuration it cannot carry out is rejected with an abort pulse, and no memory access is made.

Top module: `fbx_walker`

## Requirements
- R1: After reset, `busy`, `done`, `abort`, `rdEn` and `wrValid` are all low.
- R2: `scaleMode` uses these codes: 0 = no scaling, 1 = horizontal halving, 2 = halving in both directions. Code 3 gives a one-cycle `abort` and no read or write.
- R3: A linear source (`inLinear`=1) together with a nonzero `scaleMode` gives `abort` and no accesses.
- R4: If any of `inWidth`, `inHeight`, `outWidth` or `outHeight` is zero, the block gives `abort` and no accesses.
- R5: The effective destination width is `outWidth>>1` when `scaleMode`≠0, and `outWidth` otherwise. The effective height is `outHeight>>1` only when `scaleMode`=2. Exactly width×height writes are made, in row-major order. If either effective dimension is zero, `done` pulses and nothing is written.
- R6: The linear offset is (x + y·rowWidth)·bpp.
- R7: The tiled offset is ((x>>3)·64 + m + (y & ~7)·rowWidth)·bpp. Here m is the 6-bit value with bits, from LSB to MSB, x0, y0, x1, y1, x2, y2.
- R8: The source is tiled when `inLinear`=0, with row width `inWidth`. The destination is tiled when `inLinear` XOR `noSwizzle` is 1, with row width equal to the effective width.
- R9: For destination pixel (x,y), the source coordinate is (x<<h, y<<v), where h=1 if scaling is on and v=1 for mode 2. With `flipV`=1 the destination row becomes (effHeight−1−y); the source row is not affected by the flip.
- R10: Each pixel takes n = 1, 2 or 4 cycles (modes 0, 1, 2), with `rdEn` high in each of them. Read k goes to sourceOffset + k·srcBpp. The write appears in the last of those cycles. Each channel of the write is the sum over the n reads divided by n, with the remainder dropped.
- R11: `done` is high for exactly one cycle, the cycle after the last write. From a start pulse it comes 2 + n·pixels cycles later.
- R12: A `start` pulse while `busy` is high is ignored. The running transfer finishes with its captured configuration and raises no `abort`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Capture the configuration and begin (ignored while busy) |
| inWidth | input | DIM_W | Source width in pixels |
| inHeight | input | DIM_W | Source height in pixels |
| outWidth | input | DIM_W | Destination width before scaling |
| outHeight | input | DIM_W | Destination height before scaling |
| srcBpp | input | BPP_W | Source bytes per pixel |
| dstBpp | input | BPP_W | Destination bytes per pixel |
| inLinear | input | 1 | Source stored linearly |
| noSwizzle | input | 1 | Keep the layout kind unchanged across the copy |
| flipV | input | 1 | Mirror destination rows |
| scaleMode | input | 2 | Downscale mode code |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle completion pulse |
| abort | output | 1 | One-cycle rejection pulse |
| rdEn | output | 1 | Source read this cycle |
| rdAddr | output | ADDR_W | Source byte offset |
| rdData | input | 4*CH_W | Source pixel for rdAddr, same cycle |
| wrValid | output | 1 | Destination write this cycle |
| wrAddr | output | ADDR_W | Destination byte offset |
| wrData | output | 4*CH_W | Averaged pixel |

## Verification
The bench builds the block with DIM_W=6 and ADDR_W=16, keeping CH_W=8 and BPP_W=3. These values let the tests use images up to 18 rows and 16 columns. At that size a tiled row crosses a tile boundary in x and in y, so the coarse-column and coarse-row terms both take part in the offsets. Every byte offset the bench produces still fits in the address width without wrapping. The source model returns a pixel derived from its address, so any error in a read offset or in the averaging shows up in `wrData`.

// File: rtl/fbx_pkg.sv
package fbx_pkg;
  localparam logic [1:0] SC_NONE = 2'd0;
  localparam logic [1:0] SC_X    = 2'd1;
  localparam logic [1:0] SC_XY   = 2'd2;

  typedef enum logic [1:0] {S_IDLE, S_CHECK, S_RUN} walkState_t;

  typedef struct packed {
    logic rdEn;
    logic accAdd;
    logic emit;
  } stepCtl_t;

  function automatic logic [5:0] zInterleave(input logic [2:0] cx, input logic [2:0] cy);
    return {cy[2], cx[2], cy[1], cx[1], cy[0], cx[0]};
  endfunction
endpackage

// File: rtl/fbx_ctrl.sv
module fbx_ctrl
  import fbx_pkg::*;
#(
  parameter int DIM_W = 10,
  parameter int BPP_W = 3
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             start,
  input  logic [DIM_W-1:0] inWidth,
  input  logic [DIM_W-1:0] inHeight,
  input  logic [DIM_W-1:0] outWidth,
  input  logic [DIM_W-1:0] outHeight,
  input  logic [BPP_W-1:0] srcBpp,
  input  logic [BPP_W-1:0] dstBpp,
  input  logic             inLinear,
  input  logic             noSwizzle,
  input  logic             flipV,
  input  logic [1:0]       scaleMode,
  output logic [DIM_W-1:0] cInW,
  output logic [DIM_W-1:0] effW,
  output logic [DIM_W-1:0] effH,
  output logic [BPP_W-1:0] cSrcBpp,
  output logic [BPP_W-1:0] cDstBpp,
  output logic             cInLin,
  output logic             cNoSw,
  output logic             cFlip,
  output logic [1:0]       cScale,
  output logic [DIM_W-1:0] xPos,
  output logic [DIM_W-1:0] yPos,
  output logic [1:0]       phase,
  output stepCtl_t         step,
  output logic             busy,
  output logic             done,
  output logic             abort
);
  walkState_t state;
  logic [DIM_W-1:0] cInH, cOutW, cOutH;
  logic hShift, vShift, badCfg;
  logic [1:0] lastPh;

  assign hShift = (cScale != SC_NONE);
  assign vShift = (cScale == SC_XY);
  assign effW   = cOutW >> hShift;
  assign effH   = cOutH >> vShift;
  assign lastPh = vShift ? 2'd3 : (hShift ? 2'd1 : 2'd0);
  assign badCfg = (cScale > SC_XY) || (cInLin && cScale != SC_NONE) ||
                  (cInW == '0) || (cInH == '0) || (cOutW == '0) || (cOutH == '0);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= S_IDLE;
      cInW <= '0; cInH <= '0; cOutW <= '0; cOutH <= '0;
      cSrcBpp <= '0; cDstBpp <= '0;
      cInLin <= 1'b0; cNoSw <= 1'b0; cFlip <= 1'b0; cScale <= SC_NONE;
      xPos <= '0; yPos <= '0; phase <= '0;
      done <= 1'b0; abort <= 1'b0;
    end else begin
      done  <= 1'b0;
      abort <= 1'b0;
      case (state)
        S_IDLE: if (start) begin
          cInW <= inWidth; cInH <= inHeight; cOutW <= outWidth; cOutH <= outHeight;
          cSrcBpp <= srcBpp; cDstBpp <= dstBpp;
          cInLin <= inLinear; cNoSw <= noSwizzle; cFlip <= flipV; cScale <= scaleMode;
          state <= S_CHECK;
        end
        S_CHECK: begin
          xPos <= '0; yPos <= '0; phase <= '0;
          if (badCfg) begin
            abort <= 1'b1;
            state <= S_IDLE;
          end else if (effW == '0 || effH == '0) begin
            done  <= 1'b1;
            state <= S_IDLE;
          end else begin
            state <= S_RUN;
          end
        end
        S_RUN: begin
          if (phase != lastPh) begin
            phase <= phase + 2'd1;
          end else begin
            phase <= '0;
            if (xPos == effW - 1'b1) begin
              xPos <= '0;
              if (yPos == effH - 1'b1) begin
                done  <= 1'b1;
                state <= S_IDLE;
              end else begin
                yPos <= yPos + 1'b1;
              end
            end else begin
              xPos <= xPos + 1'b1;
            end
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  assign busy        = (state != S_IDLE);
  assign step.rdEn   = (state == S_RUN);
  assign step.emit   = (state == S_RUN) && (phase == lastPh);
  assign step.accAdd = (state == S_RUN) && (phase != lastPh);

  p_col_bound_r5: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_RUN) |-> (xPos < effW && yPos < effH));
  p_done_single_r11: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);
  p_abort_idle_r2: assert property (@(posedge clk) disable iff (!rstN)
    abort |-> !busy);
  p_excl_r4: assert property (@(posedge clk) disable iff (!rstN)
    !(done && abort));
  p_cfg_hold_r12: assert property (@(posedge clk) disable iff (!rstN)
    (busy && $past(busy)) |-> ($stable(cScale) && $stable(cInW) && $stable(cOutW)));
endmodule

// File: rtl/fbx_datapath.sv
module fbx_datapath
  import fbx_pkg::*;
#(
  parameter int DIM_W  = 10,
  parameter int BPP_W  = 3,
  parameter int ADDR_W = 24,
  parameter int CH_W   = 8
) (
  input  logic                clk,
  input  logic                rstN,
  input  stepCtl_t            step,
  input  logic [DIM_W-1:0]    xPos,
  input  logic [DIM_W-1:0]    yPos,
  input  logic [1:0]          phase,
  input  logic [DIM_W-1:0]    cInW,
  input  logic [DIM_W-1:0]    effW,
  input  logic [DIM_W-1:0]    effH,
  input  logic [BPP_W-1:0]    cSrcBpp,
  input  logic [BPP_W-1:0]    cDstBpp,
  input  logic                cInLin,
  input  logic                cNoSw,
  input  logic                cFlip,
  input  logic [1:0]          cScale,
  input  logic [4*CH_W-1:0]   rdData,
  output logic                rdEn,
  output logic [ADDR_W-1:0]   rdAddr,
  output logic                wrValid,
  output logic [ADDR_W-1:0]   wrAddr,
  output logic [4*CH_W-1:0]   wrData
);
  localparam int ACC_W = CH_W + 2;

  logic hShift, vShift;
  logic [1:0] avgShift;
  logic [DIM_W:0] srcX, srcY;
  logic [DIM_W-1:0] dstY;
  logic [ADDR_W-1:0] srcBase;

  assign hShift   = (cScale != SC_NONE);
  assign vShift   = (cScale == SC_XY);
  assign avgShift = {1'b0, hShift} + {1'b0, vShift};
  assign srcX     = {1'b0, xPos} << hShift;
  assign srcY     = {1'b0, yPos} << vShift;
  assign dstY     = cFlip ? (effH - 1'b1 - yPos) : yPos;

  function automatic logic [ADDR_W-1:0] placeOff(input logic tiled,
      input logic [ADDR_W-1:0] px, input logic [ADDR_W-1:0] py,
      input logic [ADDR_W-1:0] rowW, input logic [ADDR_W-1:0] bpp);
    logic [ADDR_W-1:0] pos;
    if (tiled)
      pos = ((px >> 3) << 6) + ADDR_W'(zInterleave(px[2:0], py[2:0])) +
            (py & ~ADDR_W'(7)) * rowW;
    else
      pos = px + py * rowW;
    return pos * bpp;
  endfunction

  assign srcBase = placeOff(!cInLin, ADDR_W'(srcX), ADDR_W'(srcY),
                            ADDR_W'(cInW), ADDR_W'(cSrcBpp));
  assign rdAddr  = srcBase + ADDR_W'(phase) * ADDR_W'(cSrcBpp);
  assign wrAddr  = placeOff(cInLin ^ cNoSw, ADDR_W'(xPos), ADDR_W'(dstY),
                            ADDR_W'(effW), ADDR_W'(cDstBpp));
  assign rdEn    = step.rdEn;
  assign wrValid = step.emit;

  for (genvar c = 0; c < 4; c++) begin : g_chan
    logic [ACC_W-1:0] acc, sum;
    assign sum = acc + ACC_W'(rdData[c*CH_W +: CH_W]);
    assign wrData[c*CH_W +: CH_W] = CH_W'(sum >> avgShift);
    always_ff @(posedge clk) begin
      if (!rstN || step.emit) acc <= '0;
      else if (step.accAdd)   acc <= sum;
    end
  end

  p_emit_reads_r10: assert property (@(posedge clk) disable iff (!rstN)
    step.emit |-> step.rdEn);
  p_add_not_emit_r10: assert property (@(posedge clk) disable iff (!rstN)
    !(step.emit && step.accAdd));
endmodule

// File: rtl/fbx_walker.sv
module fbx_walker
  import fbx_pkg::*;
#(
  parameter int DIM_W  = 10,
  parameter int BPP_W  = 3,
  parameter int ADDR_W = 24,
  parameter int CH_W   = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic [DIM_W-1:0]  inWidth,
  input  logic [DIM_W-1:0]  inHeight,
  input  logic [DIM_W-1:0]  outWidth,
  input  logic [DIM_W-1:0]  outHeight,
  input  logic [BPP_W-1:0]  srcBpp,
  input  logic [BPP_W-1:0]  dstBpp,
  input  logic              inLinear,
  input  logic              noSwizzle,
  input  logic              flipV,
  input  logic [1:0]        scaleMode,
  output logic              busy,
  output logic              done,
  output logic              abort,
  output logic              rdEn,
  output logic [ADDR_W-1:0] rdAddr,
  input  logic [4*CH_W-1:0] rdData,
  output logic              wrValid,
  output logic [ADDR_W-1:0] wrAddr,
  output logic [4*CH_W-1:0] wrData
);
  stepCtl_t step;
  logic [DIM_W-1:0] cInW, effW, effH, xPos, yPos;
  logic [BPP_W-1:0] cSrcBpp, cDstBpp;
  logic cInLin, cNoSw, cFlip;
  logic [1:0] cScale, phase;

  fbx_ctrl #(.DIM_W(DIM_W), .BPP_W(BPP_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .start(start),
    .inWidth(inWidth), .inHeight(inHeight), .outWidth(outWidth), .outHeight(outHeight),
    .srcBpp(srcBpp), .dstBpp(dstBpp), .inLinear(inLinear), .noSwizzle(noSwizzle),
    .flipV(flipV), .scaleMode(scaleMode),
    .cInW(cInW), .effW(effW), .effH(effH), .cSrcBpp(cSrcBpp), .cDstBpp(cDstBpp),
    .cInLin(cInLin), .cNoSw(cNoSw), .cFlip(cFlip), .cScale(cScale),
    .xPos(xPos), .yPos(yPos), .phase(phase), .step(step),
    .busy(busy), .done(done), .abort(abort)
  );

  fbx_datapath #(.DIM_W(DIM_W), .BPP_W(BPP_W), .ADDR_W(ADDR_W), .CH_W(CH_W)) u_dp (
    .clk(clk), .rstN(rstN), .step(step), .xPos(xPos), .yPos(yPos), .phase(phase),
    .cInW(cInW), .effW(effW), .effH(effH), .cSrcBpp(cSrcBpp), .cDstBpp(cDstBpp),
    .cInLin(cInLin), .cNoSw(cNoSw), .cFlip(cFlip), .cScale(cScale),
    .rdData(rdData), .rdEn(rdEn), .rdAddr(rdAddr),
    .wrValid(wrValid), .wrAddr(wrAddr), .wrData(wrData)
  );
endmodule

// File: tb/sim_fbx_walker.sv
module sim_fbx_walker;
  localparam int CLK_PERIOD = 10;
  localparam int DIM_W = 6, BPP_W = 3, ADDR_W = 16, CH_W = 8;

  logic clk = 1'b0, rstN = 1'b0, start = 1'b0;
  logic [DIM_W-1:0] inWidth = '0, inHeight = '0, outWidth = '0, outHeight = '0;
  logic [BPP_W-1:0] srcBpp = '0, dstBpp = '0;
  logic inLinear = 1'b0, noSwizzle = 1'b0, flipV = 1'b0;
  logic [1:0] scaleMode = '0;
  logic busy, done, abort, rdEn, wrValid;
  logic [ADDR_W-1:0] rdAddr, wrAddr;
  logic [4*CH_W-1:0] rdData, wrData;
  int nChk = 0, nFail = 0, cycles = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [31:0] pix(input logic [ADDR_W-1:0] a);
    return {a[7:0], a[15:8] ^ 8'h3C, a[7:0] + {2'b0, a[9:4]}, ~a[7:0]};
  endfunction
  assign rdData = pix(rdAddr);

  fbx_walker #(.DIM_W(DIM_W), .BPP_W(BPP_W), .ADDR_W(ADDR_W), .CH_W(CH_W)) u0 (
    .clk(clk), .rstN(rstN), .start(start), .inWidth(inWidth), .inHeight(inHeight),
    .outWidth(outWidth), .outHeight(outHeight), .srcBpp(srcBpp), .dstBpp(dstBpp),
    .inLinear(inLinear), .noSwizzle(noSwizzle), .flipV(flipV), .scaleMode(scaleMode),
    .busy(busy), .done(done), .abort(abort), .rdEn(rdEn), .rdAddr(rdAddr),
    .rdData(rdData), .wrValid(wrValid), .wrAddr(wrAddr), .wrData(wrData));

  task automatic check(input bit ok, input string req, input string what, input int act, input int exp);
    nChk++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  function automatic int zOrd(input int x, input int y);
    int m = 0;
    for (int b = 0; b < 3; b++) begin
      m = m | (((x >> b) & 1) << (2*b));
      m = m | (((y >> b) & 1) << (2*b + 1));
    end
    return m;
  endfunction

  function automatic int refOff(input bit tiled, input int x, input int y, input int rowW, input int bpp);
    if (tiled) return ((x / 8) * 64 + zOrd(x, y) + (y / 8) * 8 * rowW) * bpp;
    return (x + y * rowW) * bpp;
  endfunction

  // one transfer; pokeAt>0 pulses start with a bad configuration mid-run (R12)
  task automatic runXfer(input int iw, ih, ow, oh, sb, db, input bit lin, nsw, flp,
                         input int mode, input bit expAbort, input string req, input int pokeAt);
    int hs = (mode != 0) ? 1 : 0;
    int vs = (mode == 2) ? 1 : 0;
    int n  = 1 << (hs + vs);
    int ew = ow >> hs, eh = oh >> vs;
    int total = ew * eh;
    int idx = 0, cyc = 0, lastWr = -1, doneCyc = -1, abortCyc = -1;
    @(negedge clk);
    inWidth = DIM_W'(iw); inHeight = DIM_W'(ih); outWidth = DIM_W'(ow); outHeight = DIM_W'(oh);
    srcBpp = BPP_W'(sb); dstBpp = BPP_W'(db); inLinear = lin; noSwizzle = nsw;
    flipV = flp; scaleMode = 2'(mode); start = 1'b1;
    while (cyc < 3000) begin
      @(negedge clk);
      cyc++;
      start = (cyc == pokeAt);
      if (cyc == pokeAt) begin scaleMode = 2'd3; inWidth = '0; flipV = ~flp; end
      if (wrValid) begin
        int x = idx % ((ew > 0) ? ew : 1), y = idx / ((ew > 0) ? ew : 1);
        int oy = flp ? (eh - 1 - y) : y;
        int base = refOff(!lin, x << hs, y << vs, iw, sb);
        int sums[4] = '{0, 0, 0, 0};
        logic [31:0] expD;
        for (int k = 0; k < n; k++) begin
          logic [31:0] p = pix(ADDR_W'(base + k * sb));
          for (int c = 0; c < 4; c++) sums[c] += int'(p[c*8 +: 8]);
        end
        for (int c = 0; c < 4; c++) expD[c*8 +: 8] = 8'(sums[c] >> (hs + vs));
        check(idx < total, req, "write count overflow", idx, total);
        check(wrAddr == ADDR_W'(refOff(lin ^ nsw, x, oy, ew, db)), req, "wrAddr R6 R7 R8 R9",
              int'(wrAddr), refOff(lin ^ nsw, x, oy, ew, db));
        check(wrData == expD, req, "wrData R10", int'(wrData), int'(expD));
        check(cyc == 1 + (idx + 1) * n, "R10", "write cycle", cyc, 1 + (idx + 1) * n);
        idx++;
        lastWr = cyc;
      end
      if (done) begin doneCyc = cyc; break; end
      if (abort) begin abortCyc = cyc; break; end
    end
    start = 1'b0;
    if (expAbort) begin
      check(abortCyc == 2, req, "abort pulse cycle", abortCyc, 2);
      check(idx == 0, req, "writes on rejected transfer", idx, 0);
    end else begin
      check(doneCyc == 2 + total * n, "R11", "done cycle", doneCyc, 2 + total * n);
      check(idx == total, "R5", "write count", idx, total);
      if (total > 0) check(doneCyc == lastWr + 1, "R11", "done after last write", doneCyc, lastWr + 1);
      check(abortCyc == -1, "R12", "unexpected abort", abortCyc, -1);
    end
    @(negedge clk);
    check(!done && !abort && !busy, req, "pulse not single / still busy",
          {done, abort, busy}, 0);
  endtask

  task automatic tReset();
    check(!busy && !done && !abort && !rdEn && !wrValid, "R1", "reset outputs",
          {busy, done, abort, rdEn, wrValid}, 0);
  endtask
  task automatic tLinToLin();  runXfer(5, 3, 5, 3, 4, 3, 1, 1, 0, 0, 0, "R6", 0); endtask
  task automatic tLinToTile(); runXfer(10, 10, 10, 10, 4, 2, 1, 0, 0, 0, 0, "R7", 0); endtask
  task automatic tTileToLinX(); runXfer(16, 9, 16, 9, 4, 4, 0, 0, 0, 1, 0, "R8", 0); endtask
  task automatic tTileTileXYFlip(); runXfer(16, 16, 16, 18, 3, 2, 0, 1, 1, 2, 0, "R9", 0); endtask
  task automatic tLinFlip(); runXfer(4, 5, 4, 5, 2, 4, 1, 1, 1, 0, 0, "R9", 0); endtask
  task automatic tBadMode(); runXfer(8, 8, 8, 8, 4, 4, 0, 0, 0, 3, 1, "R2", 0); endtask
  task automatic tLinScale(); runXfer(8, 8, 8, 8, 4, 4, 1, 0, 0, 1, 1, "R3", 0); endtask
  task automatic tZeroDims();
    runXfer(0, 4, 4, 4, 4, 4, 0, 0, 0, 0, 1, "R4", 0);
    runXfer(4, 0, 4, 4, 4, 4, 0, 0, 0, 0, 1, "R4", 0);
    runXfer(4, 4, 0, 4, 4, 4, 0, 0, 0, 0, 1, "R4", 0);
    runXfer(4, 4, 4, 0, 4, 4, 0, 0, 0, 0, 1, "R4", 0);
  endtask
  task automatic tEmpty(); runXfer(8, 8, 1, 8, 4, 4, 0, 0, 0, 1, 0, "R5", 0); endtask
  task automatic tBusyStart(); runXfer(8, 4, 8, 4, 4, 4, 0, 0, 0, 1, 0, "R12", 9); endtask

  initial begin
    repeat (3) @(negedge clk);
    tReset();
    rstN = 1'b1;
    @(negedge clk);
    tReset();
    tLinToLin();
    tLinToTile();
    tTileToLinX();
    tTileTileXYFlip();
    tLinFlip();
    tBadMode();
    tLinScale();
    tZeroDims();
    tEmpty();
    tBusyStart();
    $display("%0d/%0d checks passed", nChk - nFail, nChk);
    $finish;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      nChk++; nFail++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
      $display("%0d/%0d checks passed", nChk - nFail, nChk);
      $finish;
    end
  end
endmodule